// File: doc/BRIEF.md
# Converter Interface Fault Register with Output Blanking

This block gathers fault conditions around a data converter interface into one sticky status register and, where configured, replaces the outgoing sample stream with a neutral code. It has two clock-loss watchers. Each one follows a monitored clock (the converter clock or the data clock) on the reference clock. If a monitored clock shows no edge for a set number of reference cycles, the watcher reports that the clock is gone. Two further conditions come from the FIFO: a hard pointer fault, and a proximity warning for when the pointers come too close together.

Software clears a status bit by writing zero to it, then reads the register to see which faults have appeared since that write. A separate mask register picks which hard alarms force the output samples to mid-scale. The mask resets to zero, so blanking is off until software enables it. The proximity warning is only reported. It can never blank the output.

Top module: `conv_alarm_guard`

## Requirements
- R1: During and after reset, before any fault occurs, `alarm_status` is 0, the mask is 0 and `samp_out` holds mid-scale (1 << (SW-1)).
- R2: Bit 0 of `alarm_status` (converter clock gone) sets once `conv_clk_mon` has shown no edge for GONE_LIM (16) reference cycles. It stays clear while `conv_clk_mon` toggles at least every 8 reference cycles.
- R3: Bit 1 of `alarm_status` (data clock gone) behaves like R2, driven by `data_clk_mon`.
- R4: When `fifo_ptr_err` is high at a clock edge, bit 2 of `alarm_status` is set after that edge.
- R5: When `fifo_ptr_near` is high at a clock edge, bit 3 (warning) of `alarm_status` is set after that edge.
- R6: A set alarm bit stays set after its condition goes away, until software clears it.
- R7: A write with `reg_addr` = 0 clears every status bit whose `reg_wdata` bit is 0 and leaves every bit written 1 unchanged. Writing all zeros clears the whole register.
- R8: If a condition is present in the same cycle as a clearing write, the bit ends up set.
- R9: A write with `reg_addr` = 1 loads the blanking mask from `reg_wdata[2:0]`. Mask bit i enables blanking for status bit i (i = 0..2), and `reg_wdata[3]` is ignored.
- R10: While any status bit 0..2 is set and its mask bit is 1, `samp_out` equals mid-scale, starting one cycle after the status bit becomes visible.
- R11: The warning bit (bit 3) never blanks the output, even when every mask bit is set.
- R12: When no masked alarm is active, `samp_out` equals the `samp_in` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_clk_mon | input | 1 | Monitored converter clock |
| data_clk_mon | input | 1 | Monitored data clock |
| fifo_ptr_err | input | 1 | FIFO pointer collision flag |
| fifo_ptr_near | input | 1 | FIFO pointer proximity warning |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status register, 1 = blanking mask |
| reg_wdata | input | 4 | Write data |
| samp_in | input | SW (14) | Incoming sample |
| alarm_status | output | 4 | Sticky status: conv gone, data gone, pointer fault, warning |
| samp_out | output | SW (14) | Registered, possibly blanked sample |

## Verification
A software clear and a newly raised fault can land on the same edge. The tests force this by holding `fifo_ptr_err` high during the cycle of an all-zero write to the status register, and by keeping a clock stopped while its bit is cleared. Both cases pass only if the bit reads as set afterwards. A second overlap is a cleared masked alarm while samples are still streaming. For that case the bench checks that `samp_out` moves from mid-scale back to the input exactly one cycle after the bit drops.

// File: rtl/conv_alarm_pkg.sv
package conv_alarm_pkg;
  localparam int ALM_W      = 4;
  localparam int HARD_W     = 3;
  localparam int BIT_CONV   = 0;
  localparam int BIT_DATA   = 1;
  localparam int BIT_PTR    = 2;
  localparam int BIT_WARN   = 3;
  localparam bit ADDR_ALARM = 1'b0;
  localparam bit ADDR_MASK  = 1'b1;
  typedef logic [ALM_W-1:0]  alarm_vec_t;
  typedef logic [HARD_W-1:0] mask_vec_t;
endpackage

// File: rtl/clk_watch.sv
module clk_watch #(
  parameter int GONE_LIM = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon,
  output logic gone
);
  localparam int CW = $clog2(GONE_LIM + 1);
  localparam logic [CW-1:0] LIM = CW'(GONE_LIM);

  logic          s1_q, s2_q, s3_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          edge_seen;

  always_comb begin
    edge_seen = s2_q ^ s3_q;
    if (edge_seen)
      cnt_d = '0;
    else if (cnt_q == LIM)
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= mon;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      cnt_q <= cnt_d;
    end
  end

  assign gone = (cnt_q == LIM);
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import conv_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  alarm_vec_t cond,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  alarm_vec_t reg_wdata,
  output alarm_vec_t alarm_q,
  output mask_vec_t  mask_q,
  output logic       blank
);
  alarm_vec_t alarm_d;
  mask_vec_t  mask_d;
  logic       wr_alarm, wr_mask;

  always_comb begin
    wr_alarm = reg_we && (reg_addr == ADDR_ALARM);
    wr_mask  = reg_we && (reg_addr == ADDR_MASK);
    alarm_d  = wr_alarm ? (alarm_q & reg_wdata) : alarm_q;
    alarm_d  = alarm_d | cond;
    mask_d   = wr_mask ? reg_wdata[HARD_W-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      mask_q  <= '0;
    end else begin
      alarm_q <= alarm_d;
      if (wr_mask)
        mask_q <= mask_d;
    end
  end

  assign blank = |(alarm_q[HARD_W-1:0] & mask_q);
endmodule

// File: rtl/blank_stage.sv
module blank_stage #(
  parameter int SW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank,
  input  logic [SW-1:0] samp_in,
  output logic [SW-1:0] samp_out
);
  localparam logic [SW-1:0] MID = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0] samp_d;

  always_comb begin
    samp_d = blank ? MID : samp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      samp_out <= MID;
    else
      samp_out <= samp_d;
  end
endmodule

// File: rtl/conv_alarm_guard.sv
module conv_alarm_guard
  import conv_alarm_pkg::*;
#(
  parameter int SW       = 14,
  parameter int GONE_LIM = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_clk_mon,
  input  logic          data_clk_mon,
  input  logic          fifo_ptr_err,
  input  logic          fifo_ptr_near,
  input  logic          reg_we,
  input  logic          reg_addr,
  input  logic [3:0]    reg_wdata,
  input  logic [SW-1:0] samp_in,
  output logic [3:0]    alarm_status,
  output logic [SW-1:0] samp_out
);
  localparam int NMON = 2;

  logic [NMON-1:0] mon_vec;
  logic [NMON-1:0] gone_vec;
  alarm_vec_t      cond;
  mask_vec_t       mask_q;
  logic            blank;

  assign mon_vec = {data_clk_mon, conv_clk_mon};

  for (genvar g = 0; g < NMON; g++) begin : g_watch
    clk_watch #(.GONE_LIM(GONE_LIM)) u_watch (
      .clk  (clk),
      .rst_n(rst_n),
      .mon  (mon_vec[g]),
      .gone (gone_vec[g])
    );
  end

  always_comb begin
    cond           = '0;
    cond[BIT_CONV] = gone_vec[0];
    cond[BIT_DATA] = gone_vec[1];
    cond[BIT_PTR]  = fifo_ptr_err;
    cond[BIT_WARN] = fifo_ptr_near;
  end

  alarm_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cond     (cond),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .alarm_q  (alarm_status),
    .mask_q   (mask_q),
    .blank    (blank)
  );

  blank_stage #(.SW(SW)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .blank   (blank),
    .samp_in (samp_in),
    .samp_out(samp_out)
  );
endmodule

// File: rtl/conv_alarm_guard_chk.sv
module conv_alarm_guard_chk #(
  parameter int SW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_ptr_err,
  input logic          fifo_ptr_near,
  input logic          reg_we,
  input logic          reg_addr,
  input logic [SW-1:0] samp_in,
  input logic [SW-1:0] samp_out,
  input logic [3:0]    alarm_status,
  input logic [2:0]    mask_q
);
  localparam logic [SW-1:0] MID = {1'b1, {(SW-1){1'b0}}};

  p_ptr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ptr_err |=> alarm_status[2]);

  p_warn_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ptr_near |=> alarm_status[3]);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && !reg_addr) |=> ((alarm_status & $past(alarm_status)) == $past(alarm_status)));

  p_blank_mid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(alarm_status[2:0] & mask_q)) |=> (samp_out == MID));

  p_warn_no_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_status[2:0] == 3'b000) |=> (samp_out == $past(samp_in)));

  p_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(alarm_status[2:0] & mask_q)) |=> (samp_out == $past(samp_in)));
endmodule

bind conv_alarm_guard conv_alarm_guard_chk #(.SW(SW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_ptr_err (fifo_ptr_err),
  .fifo_ptr_near(fifo_ptr_near),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .samp_in      (samp_in),
  .samp_out     (samp_out),
  .alarm_status (alarm_status),
  .mask_q       (mask_q)
);

// File: tb/tb_conv_alarm_guard.sv
`timescale 1ns/1ps
module tb_conv_alarm_guard;
  localparam int SW = 14;
  localparam int MIDV = 1 << (SW-1);

  logic          clk;
  logic          rst_n;
  logic          conv_clk_mon, data_clk_mon;
  logic          fifo_ptr_err, fifo_ptr_near;
  logic          reg_we, reg_addr;
  logic [3:0]    reg_wdata;
  logic [SW-1:0] samp_in;
  logic [3:0]    alarm_status;
  logic [SW-1:0] samp_out;

  logic conv_run, data_run;
  int   n_chk, n_bad;
  bit   done;

  conv_alarm_guard #(.SW(SW), .GONE_LIM(16)) dut (
    .clk(clk), .rst_n(rst_n),
    .conv_clk_mon(conv_clk_mon), .data_clk_mon(data_clk_mon),
    .fifo_ptr_err(fifo_ptr_err), .fifo_ptr_near(fifo_ptr_near),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .samp_in(samp_in), .alarm_status(alarm_status), .samp_out(samp_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit addr, input logic [3:0] d);
    reg_we = 1'b1; reg_addr = addr; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  // monitored clocks toggle every 3 reference cycles while enabled
  initial begin
    conv_clk_mon = 1'b0;
    data_clk_mon = 1'b0;
    forever begin
      tick(3);
      if (conv_run) conv_clk_mon = ~conv_clk_mon;
      if (data_run) data_clk_mon = ~data_clk_mon;
    end
  end

  task automatic t_reset;
    chk(alarm_status == 4'h0, "R1 status at reset", alarm_status, 0);
    chk(samp_out == SW'(MIDV), "R1 samp_out at reset", samp_out, MIDV);
  endtask

  task automatic t_clocks_ok;
    tick(60);
    wr(1'b0, 4'h0);
    tick(80);
    chk(alarm_status[0] == 1'b0, "R2 conv clock running", alarm_status[0], 0);
    chk(alarm_status[1] == 1'b0, "R3 data clock running", alarm_status[1], 0);
  endtask

  task automatic t_pass;
    for (int k = 0; k < 4; k++) begin
      samp_in = SW'(14'h0155 + k * 14'h0911);
      tick();
      chk(samp_out == samp_in, "R12 pass-through", samp_out, samp_in);
    end
  endtask

  task automatic t_ptr_err;
    fifo_ptr_err = 1'b1;
    tick();
    fifo_ptr_err = 1'b0;
    chk(alarm_status[2] == 1'b1, "R4 pointer fault bit", alarm_status[2], 1);
    samp_in = 14'h0abc;
    tick(5);
    chk(alarm_status[2] == 1'b1, "R6 bit sticky", alarm_status[2], 1);
    chk(samp_out == 14'h0abc, "R9 mask zero no blank", samp_out, 14'h0abc);
  endtask

  task automatic t_clear;
    wr(1'b0, 4'h0);
    chk(alarm_status == 4'h0, "R7 clear all", alarm_status, 0);
    fifo_ptr_err = 1'b1; fifo_ptr_near = 1'b1;
    tick();
    fifo_ptr_err = 1'b0; fifo_ptr_near = 1'b0;
    wr(1'b0, 4'b1000);
    chk(alarm_status == 4'b1000, "R7 partial clear", alarm_status, 4'b1000);
    wr(1'b0, 4'h0);
  endtask

  task automatic t_set_wins;
    fifo_ptr_err = 1'b1;
    wr(1'b0, 4'h0);
    fifo_ptr_err = 1'b0;
    chk(alarm_status == 4'b0100, "R8 set beats clear", alarm_status, 4'b0100);
    wr(1'b0, 4'h0);
  endtask

  task automatic t_mask_blank;
    wr(1'b1, 4'b0100);
    samp_in = 14'h0123;
    fifo_ptr_err = 1'b1;
    tick();
    fifo_ptr_err = 1'b0;
    chk(samp_out == 14'h0123, "R10 blank lags one cycle", samp_out, 14'h0123);
    tick();
    chk(samp_out == SW'(MIDV), "R10 blanked to mid", samp_out, MIDV);
    samp_in = 14'h0456;
    wr(1'b0, 4'h0);
    chk(samp_out == SW'(MIDV), "R10 still blank on clear edge", samp_out, MIDV);
    tick();
    chk(samp_out == 14'h0456, "R12 resume after clear", samp_out, 14'h0456);
  endtask

  task automatic t_warn;
    wr(1'b1, 4'b1111);
    samp_in = 14'h0777;
    fifo_ptr_near = 1'b1;
    tick();
    fifo_ptr_near = 1'b0;
    chk(alarm_status == 4'b1000, "R5 warning bit", alarm_status, 4'b1000);
    tick(2);
    chk(samp_out == 14'h0777, "R11 warning never blanks", samp_out, 14'h0777);
    wr(1'b0, 4'h0);
  endtask

  task automatic t_conv_gone;
    wr(1'b1, 4'b0001);
    samp_in = 14'h0222;
    conv_run = 1'b0;
    tick(30);
    chk(alarm_status[0] == 1'b1, "R2 conv clock gone", alarm_status[0], 1);
    chk(samp_out == SW'(MIDV), "R10 conv gone blanks", samp_out, MIDV);
    wr(1'b0, 4'h0);
    chk(alarm_status[0] == 1'b1, "R8 clear while clock still gone", alarm_status[0], 1);
    conv_run = 1'b1;
    tick(40);
    wr(1'b0, 4'h0);
    tick(40);
    chk(alarm_status == 4'h0, "R2 recovered clock stays clear", alarm_status, 0);
  endtask

  task automatic t_data_gone;
    wr(1'b1, 4'b0000);
    samp_in = 14'h0333;
    data_run = 1'b0;
    tick(30);
    chk(alarm_status[1] == 1'b1, "R3 data clock gone", alarm_status[1], 1);
    chk(samp_out == 14'h0333, "R9 unmasked no blank", samp_out, 14'h0333);
    data_run = 1'b1;
    tick(40);
    wr(1'b0, 4'h0);
    tick(40);
    chk(alarm_status == 4'h0, "R3 recovered clock stays clear", alarm_status, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    conv_run = 1'b1; data_run = 1'b1;
    fifo_ptr_err = 1'b0; fifo_ptr_near = 1'b0;
    reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = 4'h0;
    samp_in = 14'h1234;
    tick(4);
    t_reset();
    rst_n = 1'b1;
    tick();
    chk(alarm_status == 4'h0, "R1 status after release", alarm_status, 0);
    t_clocks_ok();
    t_pass();
    t_ptr_err();
    t_clear();
    t_set_wins();
    t_mask_blank();
    t_warn();
    t_conv_gone();
    t_data_gone();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule